// File: doc/BRIEF.md
# Flagged FIFO with Retransmit

A single-clock first-in first-out buffer for 9-bit words. Its storage depth is a power-of-two parameter. Writes and reads are requested by active-low strobes that are sampled on each rising clock edge. An asynchronous active-low master reset empties the buffer. The block drives three active-low status flags, for empty, full and more-than-half-full, computed from the positions of the read and write pointers.

Read data comes out on a registered bus together with an output-enable bit. The enable is high only in the cycle after an accepted read. While it is low the bus is driven to zero, which stands in for a high-impedance pad.

A low level on the retransmit input moves the read pointer back to storage location zero. All data written since the last master reset can then be read again, as many times as needed, provided no more than the depth has been written. Data written after a rewind is delivered behind the replayed words. If retransmit is asserted in the same cycle as a read or write strobe, the block still performs the rewind, drops the strobe and reports a protocol error.

Top module: `fifo9_rt`

## Requirements
- R1: While `rstN` is low and after it is released with no accesses, `emptyN`=0, `fullN`=1, `halfN`=1, `qOe`=0, `protoErr`=0 and `qData`=0.
- R2: Words are returned in the order they were written, all 9 bits intact. A read sampled on edge N presents its word on `qData` with `qOe`=1 after edge N.
- R3: A write sampled while the buffer holds DEPTH words is discarded. Reading back afterwards yields exactly the DEPTH earlier words and then empty.
- R4: A read sampled while the buffer is empty is discarded. `qOe` stays 0, and a later write/read pair returns the newly written word.
- R5: `qOe` is 0, and `qData` is 0, in every cycle that does not follow an accepted read.
- R6: `halfN` is 0 exactly when the stored count is at least DEPTH/2+1. A read taking the count from DEPTH/2+1 to DEPTH/2 returns it to 1.
- R7: `fullN` goes to 0 on the write that brings the count to DEPTH, and returns to 1 after the next accepted read.
- R8: A cycle with `rtN`=0 sets the read pointer to location 0. The flags then reflect the count of words written since master reset minus zero, and the following reads replay those words from the first.
- R9: Words written after a retransmit are delivered after the replayed words. A second retransmit replays the whole content again, including a full-depth content.
- R10: If `rtN`=0 in the same cycle as `wrN`=0 or `rdN`=0, `protoErr` is 1 in the next cycle, the read or write is not performed, and the rewind still takes place.
- R11: With both strobes low: on a full buffer only the read is performed; on an empty buffer only the write is performed; otherwise both are performed and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes sampled on rising edge |
| rstN | input | 1 | Asynchronous active-low master reset |
| wrN | input | 1 | Active-low write strobe |
| rdN | input | 1 | Active-low read strobe |
| rtN | input | 1 | Active-low retransmit (rewind read side) |
| dIn | input | 9 | Write data |
| qData | output | 9 | Read data, zero when not enabled |
| qOe | output | 1 | Output enable, high after an accepted read |
| emptyN | output | 1 | Low when no word is stored |
| fullN | output | 1 | Low when DEPTH words are stored |
| halfN | output | 1 | Low when more than DEPTH/2 words are stored |
| protoErr | output | 1 | High the cycle after retransmit clashed with a strobe |

## Verification
The buffer is driven with plain write bursts followed by read bursts. These show ordering and the exact count at which each flag moves, including DEPTH/2 versus DEPTH/2+1.

Overfill and underflow sequences separate a dropped access from one that silently advances a pointer. Simultaneous read and write at empty, mid and full levels separate the three precedence cases.

Rewind sequences cover three cases: a partial read, writes added after the rewind, and a full-depth content replayed twice. Together they distinguish a rewind to location zero from a rewind to any other point. Clashing strobes show that the strobe is dropped while the rewind still happens.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } memStrobe_t;
endpackage

// File: rtl/fifo9_flags.sv
module fifo9_flags #(
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(DEPTH):0]     wrPtr,
  input  logic [$clog2(DEPTH):0]     rdPtr,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       isEmpty,
  output logic                       isFull,
  output logic                       overHalf
);
  localparam int PTR_W = $clog2(DEPTH) + 1;
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_CNT = PTR_W'(DEPTH / 2 + 1);

  // occupancy from the wrapped pointers; the extra top bit separates full from empty
  always_comb begin
    count    = wrPtr - rdPtr;
    isEmpty  = (count == '0);
    isFull   = (count == FULL_CNT);
    overHalf = (count >= HALF_CNT);
  end

  // R7
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  // R6
  half_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> overHalf);
endmodule

// File: rtl/fifo9_ctrl.sv
module fifo9_ctrl
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrN,
  input  logic                         rdN,
  input  logic                         rtN,
  input  logic                         isEmpty,
  input  logic                         isFull,
  output memStrobe_t                   strobe,
  output logic [$clog2(DEPTH)-1:0]     wrAddr,
  output logic [$clog2(DEPTH)-1:0]     rdAddr,
  output logic [$clog2(DEPTH):0]       wrPtr,
  output logic [$clog2(DEPTH):0]       rdPtr,
  output logic                         protoErr
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PTR_W = AW + 1;

  logic wrReq, rdReq, rtReq, clash, wrGo, rdGo;

  always_comb begin
    wrReq = !wrN;
    rdReq = !rdN;
    rtReq = !rtN;
    clash = rtReq && (wrReq || rdReq);
    wrGo  = wrReq && !rtReq && !isFull;
    rdGo  = rdReq && !rtReq && !isEmpty;
    strobe.wrEn = wrGo;
    strobe.rdEn = rdGo;
    wrAddr = wrPtr[AW-1:0];
    rdAddr = rdPtr[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      protoErr <= 1'b0;
    end else begin
      protoErr <= clash;
      if (wrGo) wrPtr <= wrPtr + PTR_W'(1);
      if (rtReq) rdPtr <= '0;
      else if (rdGo) rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  // R3
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && isFull) |=> (wrPtr == $past(wrPtr)));
  // R4
  empty_read_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rtReq && isEmpty) |=> (rdPtr == $past(rdPtr)));
  // R8
  rewind_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rtReq |=> (rdPtr == '0));
  // R10
  clash_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    clash |=> protoErr);
  // R10
  clash_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    clash |=> (wrPtr == $past(wrPtr)));
endmodule

// File: rtl/fifo9_datapath.sv
module fifo9_datapath
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  memStrobe_t                 strobe,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  input  word_t                      dIn,
  output word_t                      qData,
  output logic                       qOe
);
  word_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrAddr] <= dIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qOe   <= 1'b0;
      qData <= '0;
    end else begin
      qOe   <= strobe.rdEn;
      qData <= strobe.rdEn ? store[rdAddr] : '0;
    end
  end

  // R5
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> (qData == '0));
endmodule

// File: rtl/fifo9_rt.sv
module fifo9_rt
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrN,
  input  logic       rdN,
  input  logic       rtN,
  input  logic [8:0] dIn,
  output logic [8:0] qData,
  output logic       qOe,
  output logic       emptyN,
  output logic       fullN,
  output logic       halfN,
  output logic       protoErr
);
  localparam int AW = $clog2(DEPTH);

  memStrobe_t     strobe;
  logic [AW-1:0]  wrAddr, rdAddr;
  logic [AW:0]    wrPtr, rdPtr, count;
  logic           isEmpty, isFull, overHalf;

  fifo9_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN),
    .isEmpty(isEmpty), .isFull(isFull), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .protoErr(protoErr)
  );

  fifo9_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rstN(rstN), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .count(count), .isEmpty(isEmpty), .isFull(isFull), .overHalf(overHalf)
  );

  fifo9_datapath #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .dIn(dIn), .qData(qData), .qOe(qOe)
  );

  assign emptyN = !isEmpty;
  assign fullN  = !isFull;
  assign halfN  = !overHalf;

  // R5
  oe_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    qOe |-> $past(emptyN));
  // R7
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(isFull && isEmpty));
endmodule

// File: tb/fifo9_rt_tb.sv
`timescale 1ns/1ps
module fifo9_rt_tb;
  localparam int D = 16;

  logic clk = 0, rstN = 0, wrN = 1, rdN = 1, rtN = 1;
  logic [8:0] dIn = '0;
  logic [8:0] qData;
  logic qOe, emptyN, fullN, halfN, protoErr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] mMem [D];
  int mWr = 0, mRd = 0;
  logic [8:0] expQ [$];

  always #4 clk = ~clk;

  fifo9_rt #(.DEPTH(D)) u_dut (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN), .dIn(dIn),
    .qData(qData), .qOe(qOe), .emptyN(emptyN), .fullN(fullN),
    .halfN(halfN), .protoErr(protoErr)
  );

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // monitor: pops expected words as the design presents them (R2)
  always @(negedge clk) begin
    if (rstN) begin
      if (qOe) begin
        if (expQ.size() == 0) chk(0, "R2 unexpected read word", qData, -1);
        else begin
          logic [8:0] e;
          e = expQ.pop_front();
          chk(qData == e, "R2 read order/data", qData, e);
        end
      end else begin
        chk(qData == 9'd0, "R5 idle bus zero", qData, 0);
      end
    end
  end

  task automatic doReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(emptyN == 1'b0, "R1 emptyN in reset", emptyN, 0);
    chk(fullN == 1'b1 && halfN == 1'b1, "R1 fullN/halfN in reset", {fullN, halfN}, 3);
    chk(qOe == 1'b0 && protoErr == 1'b0, "R1 qOe/protoErr in reset", {qOe, protoErr}, 0);
    mWr = 0; mRd = 0; expQ.delete();
    rstN = 1;
  endtask

  task automatic step(bit w, bit r, bit t, logic [8:0] d, string tag);
    int cnt;
    bit rOk, wOk, eErr;
    cnt = mWr - mRd;
    wrN = !w; rdN = !r; rtN = !t; dIn = d;
    eErr = t && (w || r);
    rOk = 0; wOk = 0;
    if (t) mRd = 0;
    else begin
      rOk = r && cnt > 0;
      wOk = w && cnt < D;
      if (rOk) begin expQ.push_back(mMem[mRd % D]); mRd++; end
      if (wOk) begin mMem[mWr % D] = d; mWr++; end
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    wrN = 1; rdN = 1; rtN = 1;
    cnt = mWr - mRd;
    chk(emptyN == (cnt != 0), {tag, " emptyN (R4)"}, emptyN, cnt != 0);
    chk(fullN == (cnt != D), {tag, " fullN (R7)"}, fullN, cnt != D);
    chk(halfN == !(cnt >= D/2 + 1), {tag, " halfN (R6)"}, halfN, !(cnt >= D/2 + 1));
    chk(qOe == rOk, {tag, " qOe (R5)"}, qOe, rOk);
    chk(protoErr == eErr, {tag, " protoErr (R10)"}, protoErr, eErr);
  endtask

  initial begin
    doReset();
    // R4: read on empty is dropped
    step(0, 1, 0, 0, "R4");
    step(1, 0, 0, 9'h1A5, "R4");
    step(0, 1, 0, 0, "R4");
    step(0, 1, 0, 0, "R4");
    // R2: short burst with bit 8 toggling
    for (int i = 0; i < 5; i++) step(1, 0, 0, 9'(i * 73 + 256 * (i % 2)), "R2");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R2");
    // R6/R7/R3: fill past full, drain through the half boundary
    for (int i = 0; i < D; i++) step(1, 0, 0, 9'(9'h100 | i), "R6");
    step(1, 0, 0, 9'h0EE, "R3");
    step(1, 0, 0, 9'h0EF, "R3");
    step(0, 1, 0, 0, "R7");
    for (int i = 0; i < D - 1; i++) step(0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, "R3");
    // R11: simultaneous at empty, mid, full
    step(1, 1, 0, 9'h011, "R11");
    step(1, 0, 0, 9'h012, "R11");
    step(1, 1, 0, 9'h013, "R11");
    step(1, 1, 0, 9'h014, "R11");
    for (int i = 0; i < D - 2; i++) step(1, 0, 0, 9'(9'h040 + i), "R11");
    step(1, 1, 0, 9'h1FF, "R11");
    for (int i = 0; i < D; i++) step(0, 1, 0, 0, "R11");
    // R8/R9: partial read, rewind, extra writes, second rewind
    doReset();
    for (int i = 0; i < 6; i++) step(1, 0, 0, 9'(9'h180 + i), "R8");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R8");
    step(0, 0, 1, 0, "R8");
    step(0, 1, 0, 0, "R8");
    step(0, 1, 0, 0, "R8");
    step(1, 0, 0, 9'h0A0, "R9");
    step(1, 0, 0, 9'h1A1, "R9");
    for (int i = 0; i < 7; i++) step(0, 1, 0, 0, "R9");
    step(0, 0, 1, 0, "R9");
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, "R9");
    // R10: clashes drop the strobe, rewind still applies
    step(0, 0, 1, 0, "R10");
    step(1, 0, 1, 9'h077, "R10");
    step(0, 1, 1, 0, "R10");
    step(0, 1, 0, 0, "R10");
    step(1, 1, 1, 9'h078, "R10");
    // R9: full-depth replay twice
    doReset();
    for (int i = 0; i < D; i++) step(1, 0, 0, 9'(i * 31), "R9");
    for (int i = 0; i < D; i++) step(0, 1, 0, 0, "R9");
    step(0, 0, 1, 0, "R8");
    for (int i = 0; i < D; i++) step(0, 1, 0, 0, "R9");
    step(0, 0, 1, 0, "R9");
    for (int i = 0; i < D; i++) step(0, 1, 0, 0, "R9");
    @(negedge clk);
    chk(expQ.size() == 0, "R2 all expected words seen", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule